// File: doc/BRIEF.md
# Second-Operand Shifter and Immediate Expander

This block forms the second source operand of a data-processing instruction, together with the carry produced by the shifter. An execution stage gives it the immediate-select bit, the 12-bit operand field of the instruction word, the values read for the shifted register and the shift-amount register, and the current carry flag. One clock later it returns the finished operand and its carry. The ALU and the flag register that use these results lie outside the block.

There are three ways to build the operand. The first expands a compact constant: an 8-bit value rotated right by an even amount from 0 to 30. The second shifts a register by a 5-bit amount held in the instruction. The third shifts a register by the low byte of a second register, so the amount can reach 255. The out-of-range cases of that last form are defined one by one so that every amount produces a known result and a known carry.

Top module: `opnd_src2_unit`

## Requirements
- R1: While rst_n is low, operand and carry_out are both zero.
- R2: When imm_sel is 1 and the rotate field op_field[11:8] is zero, operand is op_field[7:0] zero-extended to 32 bits and carry_out equals carry_in.
- R3: When imm_sel is 1 and op_field[11:8] is nonzero, operand is op_field[7:0] zero-extended and rotated right by twice that field, and carry_out equals bit 31 of operand.
- R4: When imm_sel is 0 and op_field[4] is 0, rm_val is shifted by op_field[11:7]. The type is op_field[6:5]: 00 shift left, 01 logical right, 10 arithmetic right (sign copies fill), 11 rotate right. For amounts 1 to 31, carry_out is the last bit shifted out.
- R5: When imm_sel is 0 and op_field[4] is 1, the amount is rs_val[7:0] and rs_val[31:8] has no effect. For amounts 1 to 31 the results match R4.
- R6: A shift amount of zero, from either source, gives operand equal to rm_val and carry_out equal to carry_in.
- R7: A left or logical-right shift by exactly 32 gives zero, with carry rm_val[0] for left and rm_val[31] for right. Amounts above 32 give zero with carry 0.
- R8: An arithmetic right shift by 32 or more gives 32 copies of rm_val[31], with carry equal to rm_val[31].
- R9: A rotate by 32 or more uses the amount modulo 32. A nonzero multiple of 32 returns rm_val with carry rm_val[31].
- R10: Results are registered. Inputs present at a rising clock edge appear on the outputs after that edge, and the outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imm_sel | input | 1 | 1 selects the rotated-immediate form |
| op_field | input | 12 | Operand field of the instruction word |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register holding the shift amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The bench builds the block with the default 32-bit data width and 8-bit amount width. These defaults keep the sweeps small enough to run every case. Every one of the 4096 immediate encodings is applied, along with all 32 field amounts under each shift type and every register amount from 0 to 255 under each shift type. That set covers each boundary at 31, 32 and 33, and the multiples of 32 for rotation. The bench computes each expected value by shifting one bit at a time.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int FIELD_W = 12;
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int SHAMT_W = 5;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [ROT_W-1:0]   rot;
        logic [IMM_W-1:0]   imm;
        logic [SHAMT_W-1:0] shamt;
        shift_kind_e        kind;
        logic               by_reg;
    } field_t;

    function automatic field_t split_field(input logic [FIELD_W-1:0] f);
        field_t r;
        r.rot    = f[11:8];
        r.imm    = f[7:0];
        r.shamt  = f[11:7];
        r.kind   = shift_kind_e'(f[6:5]);
        r.by_reg = f[4];
        return r;
    endfunction

endpackage

// File: rtl/opnd_ror.sv
module opnd_ror #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  res
);

    logic [W-1:0] stg [SW+1];

    assign stg[0] = val;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int D = (1 << i) % W;
        if (D == 0) begin : g_pass
            assign stg[i+1] = stg[i];
        end else begin : g_rot
            assign stg[i+1] = amt[i] ? ((stg[i] >> D) | (stg[i] << (W - D))) : stg[i];
        end
    end

    assign res = stg[SW];

endmodule

// File: rtl/opnd_imm_expand.sv
module opnd_imm_expand
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value,
    output logic              carry
);

    localparam int RA_W = ROT_W + 1;

    logic [DATA_W-1:0] base;
    logic [RA_W-1:0]   rot_amt;
    logic [DATA_W-1:0] rotated;

    assign base    = DATA_W'(imm);
    assign rot_amt = {rot, 1'b0};

    opnd_ror #(.W(DATA_W), .SW(RA_W)) u_ror (
        .val (base),
        .amt (rot_amt),
        .res (rotated)
    );

    always_comb begin
        value = rotated;
        carry = (rot == '0) ? carry_in : rotated[DATA_W-1];
    end

endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] rm,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry
);

    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   lo;
    logic              at_width;
    logic              past_width;
    logic [DATA_W-1:0] rot_val;
    logic              sign;

    assign lo         = amt[SH_W-1:0];
    assign at_width   = (amt == AMT_W'(DATA_W));
    assign past_width = (amt >  AMT_W'(DATA_W));
    assign sign       = rm[DATA_W-1];

    opnd_ror #(.W(DATA_W), .SW(SH_W)) u_ror (
        .val (rm),
        .amt (lo),
        .res (rot_val)
    );

    always_comb begin
        result = rm;
        carry  = carry_in;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    if (past_width) begin
                        result = '0;
                        carry  = 1'b0;
                    end else if (at_width) begin
                        result = '0;
                        carry  = rm[0];
                    end else begin
                        result = rm << lo;
                        carry  = rm[DATA_W - int'(lo)];
                    end
                end
                SH_LSR: begin
                    if (past_width) begin
                        result = '0;
                        carry  = 1'b0;
                    end else if (at_width) begin
                        result = '0;
                        carry  = sign;
                    end else begin
                        result = rm >> lo;
                        carry  = rm[lo - 1'b1];
                    end
                end
                SH_ASR: begin
                    if (past_width || at_width) begin
                        result = {DATA_W{sign}};
                        carry  = sign;
                    end else begin
                        result = DATA_W'($signed(rm) >>> lo);
                        carry  = rm[lo - 1'b1];
                    end
                end
                SH_ROR: begin
                    result = rot_val;
                    carry  = rot_val[DATA_W-1];
                end
                default: begin
                    result = rm;
                    carry  = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/opnd_src2_unit.sv
module opnd_src2_unit
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                imm_sel,
    input  logic [FIELD_W-1:0]  op_field,
    input  logic [DATA_W-1:0]   rm_val,
    input  logic [DATA_W-1:0]   rs_val,
    input  logic                carry_in,
    output logic [DATA_W-1:0]   operand,
    output logic                carry_out
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              cy;
    } result_t;

    field_t            fld;
    logic [DATA_W-1:0] imm_val;
    logic              imm_cy;
    logic [AMT_W-1:0]  shift_amt;
    logic [DATA_W-1:0] sh_val;
    logic              sh_cy;
    result_t           res_d;
    result_t           res_q;
    logic              unused_bits;

    assign fld         = split_field(op_field);
    assign unused_bits = ^rs_val[DATA_W-1:AMT_W];

    opnd_imm_expand #(.DATA_W(DATA_W)) u_imm (
        .imm      (fld.imm),
        .rot      (fld.rot),
        .carry_in (carry_in),
        .value    (imm_val),
        .carry    (imm_cy)
    );

    always_comb begin
        shift_amt = fld.by_reg ? rs_val[AMT_W-1:0] : AMT_W'(fld.shamt);
    end

    opnd_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .rm       (rm_val),
        .kind     (fld.kind),
        .amt      (shift_amt),
        .carry_in (carry_in),
        .result   (sh_val),
        .carry    (sh_cy)
    );

    always_comb begin
        if (imm_sel) begin
            res_d.val = imm_val;
            res_d.cy  = imm_cy;
        end else begin
            res_d.val = sh_val;
            res_d.cy  = sh_cy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign operand   = res_q.val;
    assign carry_out = res_q.cy;

    // R2: unrotated constant passes the byte through with the old carry
    a_r2_imm_plain: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(imm_sel) && ($past(op_field[11:8]) == 4'h0))
        |-> (operand == DATA_W'($past(op_field[7:0])) && carry_out == $past(carry_in)));

    // R3: rotated constant carries its own top bit
    a_r3_imm_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(imm_sel) && ($past(op_field[11:8]) != 4'h0))
        |-> (carry_out == operand[DATA_W-1] && $countones(operand) == $countones($past(op_field[7:0]))));

    // R6: register amount of zero leaves the register and carry untouched
    a_r6_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && $past(op_field[4]) && ($past(rs_val[AMT_W-1:0]) == '0))
        |-> (operand == $past(rm_val) && carry_out == $past(carry_in)));

    // R7: left shift beyond the width clears value and carry
    a_r7_lsl_far: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && $past(op_field[4]) && ($past(op_field[6:5]) == 2'b00)
         && ($past(rs_val[AMT_W-1:0]) > AMT_W'(DATA_W)))
        |-> (operand == '0 && !carry_out));

    // R8: arithmetic shift at or beyond the width gives uniform sign copies
    a_r8_asr_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && $past(op_field[4]) && ($past(op_field[6:5]) == 2'b10)
         && ($past(rs_val[AMT_W-1:0]) >= AMT_W'(DATA_W)))
        |-> ((($countones(operand) == 0) || ($countones(operand) == DATA_W))
             && carry_out == $past(rm_val[DATA_W-1])));

    // R10: outputs hold their value while a reset-free edge sees the same inputs
    a_r10_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(imm_sel) && $stable(op_field) && $stable(rm_val)
         && $stable(rs_val) && $stable(carry_in))
        |=> $stable(operand));

endmodule

// File: tb/opnd_src2_unit_tb.sv
module opnd_src2_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imm_sel = 1'b0;
    logic [11:0] op_field = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_src2_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imm_sel   (imm_sel),
        .op_field  (op_field),
        .rm_val    (rm_val),
        .rs_val    (rs_val),
        .carry_in  (carry_in),
        .operand   (operand),
        .carry_out (carry_out)
    );

    task automatic ref_model(input logic isel, input logic [11:0] f, input logic [31:0] rm,
                             input logic [31:0] rs, input logic cin,
                             output logic [31:0] v, output logic c);
        int amt;
        c = cin;
        if (isel) begin
            v = {24'h0, f[7:0]};
            amt = 2 * int'(f[11:8]);
            for (int k = 0; k < amt; k++) begin
                c = v[0];
                v = {v[0], v[31:1]};
            end
        end else begin
            v = rm;
            amt = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
            for (int k = 0; k < amt; k++) begin
                case (f[6:5])
                    2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
                    2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
                    2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
                    default: begin c = v[0]; v = {v[0], v[31:1]}; end
                endcase
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] ev, input logic ec);
        n_vec++;
        if (operand !== ev || carry_out !== ec) begin
            n_bad++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     tag, operand, carry_out, ev, ec);
        end
    endtask

    task automatic apply(input logic isel, input logic [11:0] f, input logic [31:0] rm,
                         input logic [31:0] rs, input logic cin, input string tag);
        logic [31:0] ev;
        logic        ec;
        ref_model(isel, f, rm, rs, cin, ev, ec);
        imm_sel  = isel;
        op_field = f;
        rm_val   = rm;
        rs_val   = rs;
        carry_in = cin;
        @(negedge clk);
        check(tag, ev, ec);
    endtask

    function automatic string reg_tag(input int amt, input logic [1:0] kind);
        if (amt == 0) return "R6";
        if (amt < 32) return "R5";
        if (kind == 2'b10) return "R8";
        if (kind == 2'b11) return "R9";
        return "R7";
    endfunction

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7F3C_A596;
        pats[2] = 32'hF0E1_D2C3;

        // R1: reset state
        @(negedge clk);
        imm_sel  = 1'b1;
        op_field = 12'hFFF;
        carry_in = 1'b1;
        @(negedge clk);
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: every immediate encoding
        for (int e = 0; e < 4096; e++) begin
            apply(1'b1, 12'(e), 32'hDEAD_BEEF, 32'h0, e[0] ^ e[9], (e[11:8] == 0) ? "R2" : "R3");
        end

        // R4 / R6: field amounts, all types
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int a = 0; a < 32; a++) begin
                    apply(1'b0, {5'(a), 2'(k), 1'b0, 4'hB}, pats[p], 32'hFFFF_FFFF, a[0],
                          (a == 0) ? "R6" : "R4");
                end
            end
        end

        // R5..R9: register amounts 0..255 with junk in the upper Rs bits
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int a = 0; a < 256; a++) begin
                    apply(1'b0, {4'h9, 1'b0, 2'(k), 1'b1, 4'h6}, pats[p],
                          {24'hA5C35A ^ 24'(a * 7), 8'(a)}, ~a[1],
                          reg_tag(a, 2'(k)));
                end
            end
        end

        // R10: output holds until the next rising edge, then updates
        apply(1'b1, 12'h0_3C, 32'h0, 32'h0, 1'b0, "R10");
        imm_sel  = 1'b1;
        op_field = 12'h1_FF;
        carry_in = 1'b0;
        #(CLK_PERIOD/4);
        check("R10", 32'h0000_003C, 1'b0);
        @(negedge clk);
        check("R10", 32'hC000_003F, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule